// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block translates a 32-bit virtual address into a physical address by walking a two-level page table kept in ordinary memory. A client presents the virtual address and an access kind (read, write or execute). The walker reads a first-level directory word and then a second-level table word over a simple request/response memory port. It then returns either the physical address or a fault code, together with a one-cycle completion pulse.

The address is split into three fields. Bits 31:22 index the directory. Bits 21:12 index the second-level table. Bits 11:0 are the byte offset inside a 4 KB page.

- Every table word carries a present flag.
- The final word also carries read, write and execute permissions, plus a used flag and a modified flag.
- On a successful translation the walker sets the used flag, and on a write it also sets the modified flag.
- The walker stores the final word back to memory only when one of those flags actually changed.

Only one translation is handled at a time.

Top module: `pt_walker`

## Requirements
- R1: The first memory read goes to `ptbr_base + 4 * vaddr[31:22]`.
- R2: The second memory read goes to `{dir_word[31:12], 12'h000} + 4 * vaddr[21:12]`, where `dir_word` is the directory word just read.
- R3: On success, `resp_fault` is 0 and `resp_paddr` is `{leaf_word[31:12], vaddr[11:0]}`.
- R4: Word bit 0 is the present flag.
  - If it is clear in the directory word, the walk ends after one read with `resp_fault` = 1.
  - If it is clear in the table word, the walk ends after two reads with `resp_fault` = 2.
  - Neither case performs a memory write, and `resp_paddr` is 0 on any fault.
- R5: The permission bits of the table word are bit 1 = readable, bit 2 = writable, bit 3 = executable.
  - `req_access` 0 (read), 1 (write) and 2 (execute) each need their matching bit.
  - Code 3 is never permitted.
  - A refused access ends with `resp_fault` = 3 and no memory write.
- R6: A successful access sets bit 4 (used) of the table word, and a successful write also sets bit 5 (modified). The updated word is written back to the table word address only if its value changed.
- R7: `req_ready` is high only while idle. It drops in the cycle after a request is accepted and stays low until `done`, which is a single-cycle pulse.
- R8: A memory request that is not accepted keeps `mem_req_valid`, its address and its write flag unchanged until `mem_req_ready` is high.
- R9: After reset the walker is idle: `req_ready` = 1, `done` = 0 and `mem_req_valid` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ptbr_base | input | 32 | Byte address of the directory |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Walker idle, request accepted when both high |
| req_vaddr | input | 32 | Virtual address |
| req_access | input | 2 | 0 read, 1 write, 2 execute, 3 reserved |
| done | output | 1 | One-cycle completion pulse |
| resp_paddr | output | 32 | Physical address (0 on fault) |
| resp_fault | output | 2 | 0 none, 1 directory absent, 2 table absent, 3 protection |
| mem_req_valid | output | 1 | Memory request |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_we | output | 1 | Request is a write |
| mem_req_addr | output | 32 | Memory byte address |
| mem_req_wdata | output | 32 | Write data |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data |

## Verification
The bench builds the walker with its default parameters: a 32-bit address, 10-bit indices and a 12-bit offset. This makes the real 10/10/12 split and its word-scaled address arithmetic directly observable on the memory port.

A behavioural memory with a one-cycle read latency and a stallable ready signal lets the bench reach every terminal state of the walk:
- both absent levels;
- each permission mismatch, including the reserved access code;
- the conditional write-back path;
- a request held across several refused cycles.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;
    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    typedef enum logic [1:0] {
        FLT_NONE       = 2'd0,
        FLT_DIR_ABSENT = 2'd1,
        FLT_TBL_ABSENT = 2'd2,
        FLT_PERM       = 2'd3
    } flt_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DIR_REQ,
        ST_DIR_WAIT,
        ST_TBL_REQ,
        ST_TBL_WAIT,
        ST_WB_REQ,
        ST_DONE
    } st_e;

    // flag positions inside a table word
    localparam int BIT_PRESENT = 0;
    localparam int BIT_RD      = 1;
    localparam int BIT_WR      = 2;
    localparam int BIT_EX      = 3;
    localparam int BIT_USED    = 4;
    localparam int BIT_MOD     = 5;
endpackage

// File: rtl/pt_addr_gen.sv
// Address arithmetic for both walk steps and the final physical address.
module pt_addr_gen #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 10,
    parameter int OFF_W  = 12,
    localparam int FRAME_W = ADDR_W - OFF_W
) (
    input  logic [ADDR_W-1:0]  base,
    input  logic [IDX_W-1:0]   dir_idx,
    input  logic [IDX_W-1:0]   tbl_idx,
    input  logic [FRAME_W-1:0] tbl_frame,
    input  logic [FRAME_W-1:0] leaf_frame,
    input  logic [OFF_W-1:0]   offset,
    output logic [ADDR_W-1:0]  dir_addr,
    output logic [ADDR_W-1:0]  tbl_addr,
    output logic [ADDR_W-1:0]  phys_addr
);
    // words are 4 bytes: scale each index by 4
    always_comb begin
        dir_addr  = base + (ADDR_W'(dir_idx) << 2);
        tbl_addr  = {tbl_frame, {OFF_W{1'b0}}} + (ADDR_W'(tbl_idx) << 2);
        phys_addr = {leaf_frame, offset};
    end
endmodule

// File: rtl/pt_perm_check.sv
// Permission decision and flag update for the final table word.
module pt_perm_check #(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] word,
    input  logic [1:0]        acc,
    output logic              present,
    output logic              allowed,
    output logic [ADDR_W-1:0] upd_word,
    output logic              changed
);
    import pt_walker_pkg::*;

    always_comb begin
        present = word[BIT_PRESENT];
        unique case (acc_e'(acc))
            ACC_READ:  allowed = word[BIT_RD];
            ACC_WRITE: allowed = word[BIT_WR];
            ACC_EXEC:  allowed = word[BIT_EX];
            default:   allowed = 1'b0;
        endcase
        upd_word = word;
        upd_word[BIT_USED] = 1'b1;
        if (acc_e'(acc) == ACC_WRITE) upd_word[BIT_MOD] = 1'b1;
        changed = (upd_word != word);
    end
endmodule

// File: rtl/pt_walker.sv
module pt_walker #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 10,
    parameter int OFF_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] ptbr_base,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_vaddr,
    input  logic [1:0]        req_access,
    output logic              done,
    output logic [ADDR_W-1:0] resp_paddr,
    output logic [1:0]        resp_fault,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic              mem_req_we,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [ADDR_W-1:0] mem_req_wdata,
    input  logic              mem_rsp_valid,
    input  logic [ADDR_W-1:0] mem_rsp_data
);
    import pt_walker_pkg::*;

    // ADDR_W is expected to equal OFF_W + 2*IDX_W
    localparam int FRAME_W = ADDR_W - OFF_W;

    typedef struct packed {
        st_e                st;
        logic [ADDR_W-1:0]  base;
        logic [ADDR_W-1:0]  va;
        logic [1:0]         acc;
        logic [FRAME_W-1:0] tbl_frame;
        logic [ADDR_W-1:0]  leaf;
        logic [1:0]         flt;
        logic [ADDR_W-1:0]  pa;
    } walk_t;

    walk_t r_d, r_q;

    logic [ADDR_W-1:0] dir_addr, tbl_addr, phys_addr;
    logic              leaf_present, leaf_allowed, leaf_changed;
    logic [ADDR_W-1:0] leaf_upd;

    pt_addr_gen #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) u_addr (
        .base      (r_q.base),
        .dir_idx   (r_q.va[OFF_W+IDX_W +: IDX_W]),
        .tbl_idx   (r_q.va[OFF_W +: IDX_W]),
        .tbl_frame (r_q.tbl_frame),
        .leaf_frame(mem_rsp_data[ADDR_W-1:OFF_W]),
        .offset    (r_q.va[OFF_W-1:0]),
        .dir_addr  (dir_addr),
        .tbl_addr  (tbl_addr),
        .phys_addr (phys_addr)
    );

    pt_perm_check #(.ADDR_W(ADDR_W)) u_perm (
        .word    (mem_rsp_data),
        .acc     (r_q.acc),
        .present (leaf_present),
        .allowed (leaf_allowed),
        .upd_word(leaf_upd),
        .changed (leaf_changed)
    );

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE: if (req_valid) begin
                r_d.st   = ST_DIR_REQ;
                r_d.base = ptbr_base;
                r_d.va   = req_vaddr;
                r_d.acc  = req_access;
                r_d.flt  = FLT_NONE;
                r_d.pa   = '0;
            end
            ST_DIR_REQ: if (mem_req_ready) r_d.st = ST_DIR_WAIT;
            ST_DIR_WAIT: if (mem_rsp_valid) begin
                if (!mem_rsp_data[BIT_PRESENT]) begin
                    r_d.flt = FLT_DIR_ABSENT;
                    r_d.st  = ST_DONE;
                end else begin
                    r_d.tbl_frame = mem_rsp_data[ADDR_W-1:OFF_W];
                    r_d.st        = ST_TBL_REQ;
                end
            end
            ST_TBL_REQ: if (mem_req_ready) r_d.st = ST_TBL_WAIT;
            ST_TBL_WAIT: if (mem_rsp_valid) begin
                if (!leaf_present) begin
                    r_d.flt = FLT_TBL_ABSENT;
                    r_d.st  = ST_DONE;
                end else if (!leaf_allowed) begin
                    r_d.flt = FLT_PERM;
                    r_d.st  = ST_DONE;
                end else begin
                    r_d.pa   = phys_addr;
                    r_d.leaf = leaf_upd;
                    r_d.st   = leaf_changed ? ST_WB_REQ : ST_DONE;
                end
            end
            ST_WB_REQ: if (mem_req_ready) r_d.st = ST_DONE;
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        req_ready     = (r_q.st == ST_IDLE);
        done          = (r_q.st == ST_DONE);
        resp_paddr    = r_q.pa;
        resp_fault    = r_q.flt;
        mem_req_valid = (r_q.st == ST_DIR_REQ) || (r_q.st == ST_TBL_REQ) || (r_q.st == ST_WB_REQ);
        mem_req_we    = (r_q.st == ST_WB_REQ);
        mem_req_addr  = (r_q.st == ST_DIR_REQ) ? dir_addr : tbl_addr;
        mem_req_wdata = r_q.leaf;
    end

    // ---------------- assertions ----------------
    assert_idle_after_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> req_ready && !done && !mem_req_valid);

    assert_busy_after_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> !req_ready);

    assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_phase_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({req_ready, done, mem_req_valid}));

    assert_req_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_we));

    assert_wb_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && mem_req_we |-> mem_req_wdata[BIT_PRESENT] && mem_req_wdata[BIT_USED]);

    assert_fault_no_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done && resp_fault != FLT_NONE |-> resp_paddr == '0);
endmodule

// File: tb/pt_walker_tb.sv
module pt_walker_tb;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] PTBR = 32'h0001_0000;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        req_valid = 0;
    logic [31:0] req_vaddr = '0;
    logic [1:0]  req_access = '0;
    logic        mem_req_ready = 1;
    logic        mem_rsp_valid = 0;
    logic [31:0] mem_rsp_data = '0;
    logic        req_ready, done, mem_req_valid, mem_req_we;
    logic [31:0] resp_paddr, mem_req_addr, mem_req_wdata;
    logic [1:0]  resp_fault;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pt_walker u_dut (
        .clk(clk), .rst_n(rst_n), .ptbr_base(PTBR),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_vaddr(req_vaddr), .req_access(req_access),
        .done(done), .resp_paddr(resp_paddr), .resp_fault(resp_fault),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr),
        .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data)
    );

    // behavioural memory: reads answer one cycle after acceptance
    logic [31:0] mem [int unsigned];
    int          n_rd = 0;
    int          n_wr = 0;
    logic [31:0] rd_log [64];
    logic [31:0] wr_addr_last = '0;
    logic [31:0] wr_data_last = '0;

    function automatic logic [31:0] peek(logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    always @(posedge clk) begin
        mem_rsp_valid <= 1'b0;
        if (rst_n && mem_req_valid && mem_req_ready) begin
            if (mem_req_we) begin
                mem[mem_req_addr] = mem_req_wdata;
                wr_addr_last = mem_req_addr;
                wr_data_last = mem_req_wdata;
                n_wr = n_wr + 1;
            end else begin
                mem_rsp_valid <= 1'b1;
                mem_rsp_data  <= peek(mem_req_addr);
                rd_log[n_rd % 64] = mem_req_addr;
                n_rd = n_rd + 1;
            end
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mkva(int di, int ti, int off);
        return {di[9:0], ti[9:0], off[11:0]};
    endfunction

    function automatic logic [31:0] dir_at(int di);
        return PTBR + 32'(di) * 4;
    endfunction

    function automatic logic [31:0] tbl_at(int ti);
        return 32'h0002_0000 + 32'(ti) * 4;
    endfunction

    logic [31:0] got_pa;
    logic [1:0]  got_flt;
    int          rd0, wr0;

    // issue one translation and wait for its completion pulse
    task automatic walk(logic [31:0] va, logic [1:0] acc);
        @(negedge clk);
        rd0 = n_rd; wr0 = n_wr;
        req_vaddr = va; req_access = acc; req_valid = 1;
        @(negedge clk);
        req_valid = 0;
        chk("R7 ready low after accept", {31'b0, req_ready}, 32'd0);
        while (!done) @(negedge clk);
        got_pa = resp_paddr; got_flt = resp_fault;
        @(negedge clk);
        chk("R7 done single pulse", {31'b0, done}, 32'd0);
        chk("R7 ready back high", {31'b0, req_ready}, 32'd1);
    endtask

    task automatic t_reset;
        chk("R9 reset req_ready", {31'b0, req_ready}, 32'd1);
        chk("R9 reset done", {31'b0, done}, 32'd0);
        chk("R9 reset mem_req_valid", {31'b0, mem_req_valid}, 32'd0);
    endtask

    task automatic t_read_first;
        walk(mkva(3, 5, 12'hABC), 2'd0);
        chk("R1 directory read address", rd_log[rd0 % 64], dir_at(3));
        chk("R2 table read address", rd_log[(rd0 + 1) % 64], tbl_at(5));
        chk("R3 read paddr", got_pa, 32'h1234_5ABC);
        chk("R3 read fault", {30'b0, got_flt}, 32'd0);
        chk("R6 used write count", 32'(n_wr - wr0), 32'd1);
        chk("R6 used write addr", wr_addr_last, tbl_at(5));
        chk("R6 used write data", wr_data_last, 32'h1234_5013);
    endtask

    task automatic t_read_again;
        walk(mkva(3, 5, 12'h004), 2'd0);
        chk("R3 repeat paddr", got_pa, 32'h1234_5004);
        chk("R6 no write when unchanged", 32'(n_wr - wr0), 32'd0);
    endtask

    task automatic t_write_denied;
        walk(mkva(3, 5, 12'h010), 2'd1);
        chk("R5 write without W fault", {30'b0, got_flt}, 32'd3);
        chk("R5 no write on fault", 32'(n_wr - wr0), 32'd0);
        chk("R5 entry unchanged", peek(tbl_at(5)), 32'h1234_5013);
        chk("R4 paddr zero on fault", got_pa, 32'd0);
    endtask

    task automatic t_write_ok;
        walk(mkva(3, 6, 12'h7F0), 2'd1);
        chk("R3 write paddr", got_pa, 32'h0ABC_D7F0);
        chk("R6 dirty write data", wr_data_last, 32'h0ABC_D037);
        chk("R6 dirty write count", 32'(n_wr - wr0), 32'd1);
    endtask

    task automatic t_exec;
        walk(mkva(3, 6, 12'h000), 2'd2);
        chk("R5 exec without X fault", {30'b0, got_flt}, 32'd3);
        walk(mkva(3, 7, 12'h123), 2'd2);
        chk("R5 exec with X fault", {30'b0, got_flt}, 32'd0);
        chk("R3 exec paddr", got_pa, 32'h0077_7123);
        chk("R6 exec no write (used set)", 32'(n_wr - wr0), 32'd0);
        walk(mkva(3, 6, 12'h000), 2'd3);
        chk("R5 reserved access fault", {30'b0, got_flt}, 32'd3);
    endtask

    task automatic t_absent;
        walk(mkva(9, 0, 12'h000), 2'd0);
        chk("R4 directory absent fault", {30'b0, got_flt}, 32'd1);
        chk("R4 directory absent one read", 32'(n_rd - rd0), 32'd1);
        walk(mkva(3, 8, 12'h000), 2'd0);
        chk("R4 table absent fault", {30'b0, got_flt}, 32'd2);
        chk("R4 table absent two reads", 32'(n_rd - rd0), 32'd2);
        chk("R4 table absent no write", 32'(n_wr - wr0), 32'd0);
    endtask

    task automatic t_stall;
        fork
            walk(mkva(3, 5, 12'h3FC), 2'd0);
            begin
                @(negedge clk);
                mem_req_ready = 0;
                repeat (2) @(negedge clk);
                chk("R8 request held while stalled", {31'b0, mem_req_valid}, 32'd1);
                chk("R8 address held while stalled", mem_req_addr, dir_at(3));
                repeat (3) @(negedge clk);
                mem_req_ready = 1;
            end
        join
        chk("R8 stalled walk paddr", got_pa, 32'h1234_53FC);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        mem[dir_at(3)] = 32'h0002_0001;
        mem[tbl_at(5)] = 32'h1234_5003;
        mem[tbl_at(6)] = 32'h0ABC_D007;
        mem[tbl_at(7)] = 32'h0077_7019;
        mem[tbl_at(8)] = 32'h5555_5006;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_read_first();
        t_read_again();
        t_write_denied();
        t_write_ok();
        t_exec();
        t_absent();
        t_stall();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule